// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the byte-wide programming port of one priority interrupt controller. A host reaches it through a single address line (even and odd address) with write and read strobes. Writes are decoded into a multi-word initialization sequence, into operation commands (end-of-interrupt, priority rotation, rotate-on-auto-EOI) and into read and poll control. The results leave the block as configuration fields and as one-cycle update strobes for a separate resolver core. That core owns the request and in-service registers and the priority arithmetic.

The resolver feeds back its request and in-service registers, the highest in-service line and the highest pending line. These let the block carry out non-specific end-of-interrupt commands and answer poll reads. Reads return the mask register at the odd address. At the even address they return either the poll result or the selected request or in-service register. All update strobes are registered and appear in the cycle after the write that caused them.

Top module: `picif_cmd_regs`

## Requirements
- R1: After reset the mask is 0x00, initialization is idle, the priority base is 0, all strobes are low, and an even-address read returns the request register (read select = request).
- R2: An even-address write with bit 4 set starts initialization. In the next cycle `init_busy_o` is high and `irq_drop_o` pulses. Bit 0 is latched as "fourth word expected" and bit 1 as single mode (`single_o`). Nested mode and auto-EOI are cleared.
- R3: The first odd-address word after the start sets `vec_base_o` to the data AND 0xF8. The next word is taken as the fourth word only when single mode and "fourth word expected" are both set. Otherwise the next word is the third word.
- R4: The third word ends initialization when no fourth word is expected, and otherwise moves on to the fourth word. The fourth word always ends initialization.
- R5: In the fourth word, bit 4 sets `nested_o` and bit 1 sets `auto_eoi_o`.
- R6: An odd-address write while initialization is idle loads the mask register. An odd-address write during initialization leaves the mask unchanged. An odd-address read returns the mask.
- R7: An even-address write with bit 3 set and bit 4 clear is a read-control word. If bit 1 is set, bit 0 selects what even reads return: 1 gives the in-service register, 0 gives the request register. If bit 1 is clear, the selection is kept.
- R8: In a read-control word, bit 6 set copies bit 5 into `smask_o`. Bit 6 clear leaves `smask_o` unchanged.
- R9: A read-control word with bit 2 set makes the next even-address read return the poll result. That result is 0x80 OR the pending line when a request exists, and 0x00 otherwise. That read clears the pending poll. When a line was found, `poll_ack_o` pulses with the line in the next cycle.
- R10: An operation command (even address, bits 4 and 3 clear, code = bits 7:5) with code 0 clears `rot_aeoi_o`, and with code 4 sets it.
- R11: Code 1 pulses `isr_clr_o` with the one-hot bit of the highest in-service line. Code 5 does the same and also pulses `prio_set_o` with base = line + 1 mod 8. When no line is in service, neither code has any effect.
- R12: Code 3 clears in-service bit (data AND 7). Code 6 sets the base to (data AND 7) + 1 mod 8. Code 7 does both. Code 2 has no effect. `prio_base_o` holds its value between updates.
- R13: `irq_drop_o`, `isr_clr_o` and `prio_set_o` are high for exactly one cycle per causing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_a0 | input | 1 | Address bit: 0 even, 1 odd |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| core_irr | input | 8 | Request register from the resolver |
| core_isr | input | 8 | In-service register from the resolver |
| top_isr_vld | input | 1 | Some line is in service |
| top_isr_line | input | 3 | Highest-priority in-service line |
| poll_vld | input | 1 | Some unmasked request is pending |
| poll_line | input | 3 | Highest-priority pending line |
| mask_o | output | 8 | Mask register |
| vec_base_o | output | 8 | Vector base (low three bits zero) |
| single_o | output | 1 | Single (non-cascaded) mode |
| nested_o | output | 1 | Special fully nested mode |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| smask_o | output | 1 | Special mask flag |
| init_busy_o | output | 1 | Initialization sequence in progress |
| irq_drop_o | output | 1 | Pulse: drop pending interrupt output |
| isr_clr_o | output | 8 | Pulse: one-hot in-service bit to clear |
| prio_set_o | output | 1 | Pulse: priority base was updated |
| prio_base_o | output | 3 | Current priority base (lowest-numbered highest priority line) |
| poll_ack_o | output | 1 | Pulse: poll read consumed a request |
| poll_ack_line_o | output | 3 | Line consumed by the poll read |

## Verification
The hardest paths to reach are the initialization branches that depend on flags from an earlier word. The stimulus runs three separate start words: cascaded with a fourth word, single with a fourth word, and single without a fourth word. After each, it observes through `init_busy_o` and the mask read-back which word the block takes as the last one. In the last case the third word is written as 0xFF to show that it is consumed and never reaches the mask. The wrapping of the priority base is reached with the in-service line set to 7 and a specific rotate to line 7, both of which must give a base of 0.

// File: rtl/picif_pkg.sv
package picif_pkg;
    localparam int BYTE_W = 8;
    localparam int LINES  = 8;
    localparam int LINE_W = $clog2(LINES);

    typedef enum logic [1:0] {
        INIT_IDLE = 2'd0,
        INIT_W2   = 2'd1,
        INIT_W3   = 2'd2,
        INIT_W4   = 2'd3
    } init_st_e;

    typedef struct packed {
        init_st_e          st;
        logic              icw4;
        logic              single;
        logic [BYTE_W-1:0] vbase;
        logic              nested;
        logic              aeoi;
        logic              drop;
        logic [BYTE_W-1:0] mask;
    } init_s_t;

    typedef struct packed {
        logic              rsel;
        logic              smask;
        logic              poll;
        logic              rot;
        logic [LINES-1:0]  isr_clr;
        logic              prio_set;
        logic [LINE_W-1:0] prio_base;
        logic              pack;
        logic [LINE_W-1:0] pack_line;
    } ocw_s_t;
endpackage

// File: rtl/picif_init_seq.sv
module picif_init_seq
    import picif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              a0_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              drop_o,
    output logic              single_o,
    output logic [BYTE_W-1:0] vbase_o,
    output logic              nested_o,
    output logic              aeoi_o,
    output logic [BYTE_W-1:0] mask_o
);
    localparam logic [BYTE_W-1:0] BASE_MASK = ~BYTE_W'(LINES - 1);

    init_s_t s_d, s_q;
    logic    start;

    always_comb begin
        s_d      = s_q;
        s_d.drop = 1'b0;
        start    = wr_i && !a0_i && wdata_i[4];
        if (start) begin
            s_d.st     = INIT_W2;
            s_d.icw4   = wdata_i[0];
            s_d.single = wdata_i[1];
            s_d.nested = 1'b0;
            s_d.aeoi   = 1'b0;
            s_d.drop   = 1'b1;
        end else if (wr_i && a0_i) begin
            case (s_q.st)
                INIT_IDLE: s_d.mask = wdata_i;
                INIT_W2: begin
                    s_d.vbase = wdata_i & BASE_MASK;
                    s_d.st    = (s_q.single && s_q.icw4) ? INIT_W4 : INIT_W3;
                end
                INIT_W3: s_d.st = s_q.icw4 ? INIT_W4 : INIT_IDLE;
                INIT_W4: begin
                    s_d.nested = wdata_i[4];
                    s_d.aeoi   = wdata_i[1];
                    s_d.st     = INIT_IDLE;
                end
                default: s_d.st = INIT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o   = (s_q.st != INIT_IDLE);
    assign drop_o   = s_q.drop;
    assign single_o = s_q.single;
    assign vbase_o  = s_q.vbase;
    assign nested_o = s_q.nested;
    assign aeoi_o   = s_q.aeoi;
    assign mask_o   = s_q.mask;

    // R2
    icw1_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !a0_i && wdata_i[4]) |=> (drop_o && busy_o));
    // R6
    init_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_i && a0_i) |=> $stable(mask_o));
    // R13
    drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> $past(wr_i && !a0_i && wdata_i[4]));
endmodule

// File: rtl/picif_ocw_dec.sv
module picif_ocw_dec
    import picif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              a0_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              top_vld_i,
    input  logic [LINE_W-1:0] top_line_i,
    input  logic              poll_vld_i,
    input  logic [LINE_W-1:0] poll_line_i,
    output logic              rsel_o,
    output logic              smask_o,
    output logic              poll_pend_o,
    output logic              rot_o,
    output logic [LINES-1:0]  isr_clr_o,
    output logic              prio_set_o,
    output logic [LINE_W-1:0] prio_base_o,
    output logic              pack_o,
    output logic [LINE_W-1:0] pack_line_o
);
    ocw_s_t            s_d, s_q;
    logic [2:0]        code;
    logic [LINE_W-1:0] spec_line;

    assign code      = wdata_i[7:5];
    assign spec_line = wdata_i[LINE_W-1:0];

    always_comb begin
        s_d          = s_q;
        s_d.isr_clr  = '0;
        s_d.prio_set = 1'b0;
        s_d.pack     = 1'b0;
        if (rd_i && !a0_i && s_q.poll) begin
            s_d.poll = 1'b0;
            if (poll_vld_i) begin
                s_d.pack      = 1'b1;
                s_d.pack_line = poll_line_i;
            end
        end
        if (wr_i && !a0_i && !wdata_i[4]) begin
            if (wdata_i[3]) begin
                if (wdata_i[2]) s_d.poll  = 1'b1;
                if (wdata_i[1]) s_d.rsel  = wdata_i[0];
                if (wdata_i[6]) s_d.smask = wdata_i[5];
            end else begin
                case (code)
                    3'd0, 3'd4: s_d.rot = code[2];
                    3'd1, 3'd5: begin
                        if (top_vld_i) begin
                            s_d.isr_clr = LINES'(1) << top_line_i;
                            if (code[2]) begin
                                s_d.prio_set  = 1'b1;
                                s_d.prio_base = top_line_i + 1'b1;
                            end
                        end
                    end
                    3'd3: s_d.isr_clr = LINES'(1) << spec_line;
                    3'd6: begin
                        s_d.prio_set  = 1'b1;
                        s_d.prio_base = spec_line + 1'b1;
                    end
                    3'd7: begin
                        s_d.isr_clr   = LINES'(1) << spec_line;
                        s_d.prio_set  = 1'b1;
                        s_d.prio_base = spec_line + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsel_o      = s_q.rsel;
    assign smask_o     = s_q.smask;
    assign poll_pend_o = s_q.poll;
    assign rot_o       = s_q.rot;
    assign isr_clr_o   = s_q.isr_clr;
    assign prio_set_o  = s_q.prio_set;
    assign prio_base_o = s_q.prio_base;
    assign pack_o      = s_q.pack;
    assign pack_line_o = s_q.pack_line;

    // R11
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_clr_o));
    // R13
    prio_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_set_o |-> $past(wr_i && !a0_i && !wdata_i[4] && !wdata_i[3]));
    // R12
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_set_o |-> $stable(prio_base_o));
    // R9
    poll_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pack_o |-> $past(rd_i && !a0_i && poll_pend_o));
endmodule

// File: rtl/picif_rd_mux.sv
module picif_rd_mux
    import picif_pkg::*;
(
    input  logic              a0_i,
    input  logic              poll_pend_i,
    input  logic              poll_vld_i,
    input  logic [LINE_W-1:0] poll_line_i,
    input  logic              rsel_i,
    input  logic [BYTE_W-1:0] irr_i,
    input  logic [BYTE_W-1:0] isr_i,
    input  logic [BYTE_W-1:0] mask_i,
    output logic [BYTE_W-1:0] rdata_o
);
    always_comb begin
        if (a0_i) begin
            rdata_o = mask_i;
        end else if (poll_pend_i) begin
            rdata_o = '0;
            if (poll_vld_i) begin
                rdata_o[BYTE_W-1]   = 1'b1;
                rdata_o[LINE_W-1:0] = poll_line_i;
            end
        end else begin
            rdata_o = rsel_i ? isr_i : irr_i;
        end
    end
endmodule

// File: rtl/picif_cmd_regs.sv
module picif_cmd_regs
    import picif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_a0,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        core_irr,
    input  logic [7:0]        core_isr,
    input  logic              top_isr_vld,
    input  logic [2:0]        top_isr_line,
    input  logic              poll_vld,
    input  logic [2:0]        poll_line,
    output logic [7:0]        mask_o,
    output logic [7:0]        vec_base_o,
    output logic              single_o,
    output logic              nested_o,
    output logic              auto_eoi_o,
    output logic              rot_aeoi_o,
    output logic              smask_o,
    output logic              init_busy_o,
    output logic              irq_drop_o,
    output logic [7:0]        isr_clr_o,
    output logic              prio_set_o,
    output logic [2:0]        prio_base_o,
    output logic              poll_ack_o,
    output logic [2:0]        poll_ack_line_o
);
    logic rsel_w;
    logic poll_pend_w;

    picif_init_seq u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .a0_i     (bus_a0),
        .wdata_i  (bus_wdata),
        .busy_o   (init_busy_o),
        .drop_o   (irq_drop_o),
        .single_o (single_o),
        .vbase_o  (vec_base_o),
        .nested_o (nested_o),
        .aeoi_o   (auto_eoi_o),
        .mask_o   (mask_o)
    );

    picif_ocw_dec u_ocw (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wr),
        .rd_i        (bus_rd),
        .a0_i        (bus_a0),
        .wdata_i     (bus_wdata),
        .top_vld_i   (top_isr_vld),
        .top_line_i  (top_isr_line),
        .poll_vld_i  (poll_vld),
        .poll_line_i (poll_line),
        .rsel_o      (rsel_w),
        .smask_o     (smask_o),
        .poll_pend_o (poll_pend_w),
        .rot_o       (rot_aeoi_o),
        .isr_clr_o   (isr_clr_o),
        .prio_set_o  (prio_set_o),
        .prio_base_o (prio_base_o),
        .pack_o      (poll_ack_o),
        .pack_line_o (poll_ack_line_o)
    );

    picif_rd_mux u_rd (
        .a0_i        (bus_a0),
        .poll_pend_i (poll_pend_w),
        .poll_vld_i  (poll_vld),
        .poll_line_i (poll_line),
        .rsel_i      (rsel_w),
        .irr_i       (core_irr),
        .isr_i       (core_isr),
        .mask_i      (mask_o),
        .rdata_o     (bus_rdata)
    );
endmodule

// File: tb/picif_cmd_regs_test.sv
`timescale 1ns/1ps
module picif_cmd_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_a0 = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] core_irr = 8'h5A, core_isr = 8'h81;
    logic       top_isr_vld = 1'b0;
    logic [2:0] top_isr_line = '0;
    logic       poll_vld = 1'b0;
    logic [2:0] poll_line = '0;
    logic [7:0] mask_o, vec_base_o, isr_clr_o;
    logic       single_o, nested_o, auto_eoi_o, rot_aeoi_o, smask_o;
    logic       init_busy_o, irq_drop_o, prio_set_o, poll_ack_o;
    logic [2:0] prio_base_o, poll_ack_line_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    picif_cmd_regs uut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_a0 = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_a0 = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 mask", mask_o, 8'h00);
        chk("R1 busy", {7'd0, init_busy_o}, 8'h00);
        chk("R1 base", {5'd0, prio_base_o}, 8'h00);
        chk("R1 strobes", {isr_clr_o}, 8'h00);
        rd(1'b0, v);
        chk("R1 even read irr", v, 8'h5A);
    endtask

    task automatic t_init_full();
        logic [7:0] v;
        wr(1'b0, 8'h11);
        chk("R2 drop", {7'd0, irq_drop_o}, 8'h01);
        chk("R2 busy", {7'd0, init_busy_o}, 8'h01);
        chk("R2 single", {7'd0, single_o}, 8'h00);
        @(negedge clk);
        chk("R13 drop pulse", {7'd0, irq_drop_o}, 8'h00);
        wr(1'b1, 8'h6F);
        chk("R3 base", vec_base_o, 8'h68);
        chk("R3 still busy", {7'd0, init_busy_o}, 8'h01);
        wr(1'b1, 8'h04);
        chk("R4 after third", {7'd0, init_busy_o}, 8'h01);
        chk("R6 mask held", mask_o, 8'h00);
        wr(1'b1, 8'h12);
        chk("R5 nested", {7'd0, nested_o}, 8'h01);
        chk("R5 aeoi", {7'd0, auto_eoi_o}, 8'h01);
        chk("R4 done", {7'd0, init_busy_o}, 8'h00);
        rd(1'b1, v);
        chk("R6 mask after init", v, 8'h00);
    endtask

    task automatic t_init_skip();
        wr(1'b0, 8'h13);
        chk("R2 single set", {7'd0, single_o}, 8'h01);
        chk("R2 nested cleared", {7'd0, nested_o}, 8'h00);
        wr(1'b1, 8'h20);
        chk("R3 base 20", vec_base_o, 8'h20);
        wr(1'b1, 8'h02);
        chk("R3 skip to fourth aeoi", {7'd0, auto_eoi_o}, 8'h01);
        chk("R3 skip nested", {7'd0, nested_o}, 8'h00);
        chk("R3 skip done", {7'd0, init_busy_o}, 8'h00);
    endtask

    task automatic t_init_no4();
        logic [7:0] v;
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h08);
        chk("R3 single no4 busy", {7'd0, init_busy_o}, 8'h01);
        wr(1'b1, 8'hFF);
        chk("R4 third ends", {7'd0, init_busy_o}, 8'h00);
        chk("R6 third not mask", mask_o, 8'h00);
        wr(1'b1, 8'hA5);
        rd(1'b1, v);
        chk("R6 mask load", v, 8'hA5);
    endtask

    task automatic t_rsel();
        logic [7:0] v;
        wr(1'b0, 8'h0B);
        rd(1'b0, v);
        chk("R7 isr select", v, 8'h81);
        wr(1'b0, 8'h08);
        rd(1'b0, v);
        chk("R7 select kept", v, 8'h81);
        wr(1'b0, 8'h0A);
        rd(1'b0, v);
        chk("R7 irr select", v, 8'h5A);
    endtask

    task automatic t_smask();
        wr(1'b0, 8'h68);
        chk("R8 smask set", {7'd0, smask_o}, 8'h01);
        wr(1'b0, 8'h08);
        chk("R8 smask kept", {7'd0, smask_o}, 8'h01);
        wr(1'b0, 8'h48);
        chk("R8 smask clear", {7'd0, smask_o}, 8'h00);
    endtask

    task automatic t_poll();
        logic [7:0] v;
        poll_vld = 1'b1; poll_line = 3'd5;
        wr(1'b0, 8'h0C);
        rd(1'b0, v);
        chk("R9 poll data", v, 8'h85);
        chk("R9 poll ack", {7'd0, poll_ack_o}, 8'h01);
        chk("R9 ack line", {5'd0, poll_ack_line_o}, 8'h05);
        rd(1'b0, v);
        chk("R9 poll once", v, 8'h5A);
        chk("R9 no ack", {7'd0, poll_ack_o}, 8'h00);
        poll_vld = 1'b0;
        wr(1'b0, 8'h0C);
        rd(1'b0, v);
        chk("R9 poll empty", v, 8'h00);
        chk("R9 empty no ack", {7'd0, poll_ack_o}, 8'h00);
    endtask

    task automatic t_rot();
        wr(1'b0, 8'h80);
        chk("R10 rot set", {7'd0, rot_aeoi_o}, 8'h01);
        wr(1'b0, 8'h00);
        chk("R10 rot clear", {7'd0, rot_aeoi_o}, 8'h00);
    endtask

    task automatic t_eoi_top();
        top_isr_vld = 1'b1; top_isr_line = 3'd6;
        wr(1'b0, 8'h20);
        chk("R11 code1 clr", isr_clr_o, 8'h40);
        chk("R11 code1 no base", {7'd0, prio_set_o}, 8'h00);
        @(negedge clk);
        chk("R13 clr pulse", isr_clr_o, 8'h00);
        wr(1'b0, 8'hA0);
        chk("R11 code5 clr", isr_clr_o, 8'h40);
        chk("R11 code5 set", {7'd0, prio_set_o}, 8'h01);
        chk("R11 code5 base", {5'd0, prio_base_o}, 8'h07);
        @(negedge clk);
        chk("R13 set pulse", {7'd0, prio_set_o}, 8'h00);
        top_isr_line = 3'd7;
        wr(1'b0, 8'hA0);
        chk("R11 base wrap", {5'd0, prio_base_o}, 8'h00);
        top_isr_vld = 1'b0;
        wr(1'b0, 8'h20);
        chk("R11 none in service", isr_clr_o, 8'h00);
        wr(1'b0, 8'hA0);
        chk("R11 none no set", {7'd0, prio_set_o}, 8'h00);
    endtask

    task automatic t_eoi_spec();
        wr(1'b0, 8'hE2);
        chk("R12 code7 clr", isr_clr_o, 8'h04);
        chk("R12 code7 base", {5'd0, prio_base_o}, 8'h03);
        wr(1'b0, 8'h63);
        chk("R12 code3 clr", isr_clr_o, 8'h08);
        chk("R12 code3 base kept", {5'd0, prio_base_o}, 8'h03);
        wr(1'b0, 8'hC7);
        chk("R12 code6 base", {5'd0, prio_base_o}, 8'h00);
        chk("R12 code6 no clr", isr_clr_o, 8'h00);
        wr(1'b0, 8'hE2);
        wr(1'b0, 8'h40);
        chk("R12 code2 clr", isr_clr_o, 8'h00);
        chk("R12 code2 base", {5'd0, prio_base_o}, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_full();
        t_init_skip();
        t_init_no4();
        t_rsel();
        t_smask();
        t_poll();
        t_rot();
        t_eoi_top();
        t_eoi_spec();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule